// File: doc/BRIEF.md
# Double-Buffer Address Register Unit

This block keeps the address registers that let a vector engine work on one half of its data memory while the other half is being filled. A base address and a buffer offset, both 10 bits wide, describe the two halves. A one-bit buffer flag says which half is currently open for writing. The write-side pointer TOPS and the engine-side pointer TOP are derived from these. A staged pointer ITOPS and its live copy ITOP carry a separate value into the engine when a microprogram starts.

A command decoder outside the block raises one of three write strobes: set-base, set-offset or set-ITOPS. It also raises a start strobe when a microprogram is launched. All of these share one 16-bit immediate bus. On start, the block swaps the buffers in one clock edge and copies ITOPS into ITOP. The parameter `FLIP_EN` builds the variant that swaps buffers. With `FLIP_EN = 0`, a start only copies ITOPS into ITOP.

A registered read port returns any register or a status word. The status word carries a copy of the buffer flag. TOPS, TOP, ITOP and the flag are also driven directly from their registers.

Top module: `dbuf_addr_unit`

## Requirements
- R1: When `set_offset` is high, the low 10 bits of `imm` go into OFFSET, the buffer flag is cleared, and TOPS takes the BASE value held before that edge. Bits 15..10 of `imm` are ignored.
- R2: When `set_base` is high, the low 10 bits of `imm` go into BASE. TOPS, TOP and the flag keep their values.
- R3: When `set_itops` is high, the low 10 bits of `imm` go into ITOPS.
- R4: When `mp_start` is high and `FLIP_EN = 1`, three things happen at the same edge. TOP takes the old TOPS. The flag inverts. TOPS becomes BASE + OFFSET if the new flag is 1, or BASE if the new flag is 0.
- R5: On the read port, select 6 returns the flag in bit 0. Select 7 returns the status word, which holds the flag in bit 7 and zeros elsewhere. The status bit always equals the current flag.
- R6: When `mp_start` is high, ITOP takes the ITOPS value held before that edge. This holds in both variants.
- R7: When several strobes are high in one cycle, every update uses the register values from before that edge. On the flag, TOPS and TOP, a flip takes precedence over the clearing done by set-offset. OFFSET, BASE and ITOPS are still written.
- R8: A synchronous active-high `rst` clears every register and `rd_data` to zero.
- R9: With `FLIP_EN = 0`, `mp_start` leaves the flag, TOPS and TOP unchanged.
- R10: The sum BASE + OFFSET wraps modulo 1024.
- R11: The read port is registered. `rd_data` shows, one edge after `rd_sel` is applied, the value selected from the registers as they were before that edge. The select codes are 0 BASE, 1 OFFSET, 2 TOPS, 3 TOP, 4 ITOPS, 5 ITOP. Each value is zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_base | input | 1 | Write BASE from `imm` |
| set_offset | input | 1 | Write OFFSET from `imm` and reset the buffer state |
| set_itops | input | 1 | Write ITOPS from `imm` |
| mp_start | input | 1 | Microprogram start: buffer swap and ITOP load |
| imm | input | 16 | Immediate field shared by all writes |
| rd_sel | input | 3 | Read port select |
| rd_data | output | 32 | Registered read data |
| buf_flag | output | 1 | Buffer flag |
| tops_addr | output | 10 | Write-side buffer pointer |
| top_addr | output | 10 | Engine-side buffer pointer |
| itop_val | output | 10 | Live ITOP value |

## Verification
The hardest case to reach is a start strobe in the same cycle as a register write. Here the old and new values of BASE, OFFSET or ITOPS must land in different registers at a single edge. The stimulus table places set-offset, set-base and set-ITOPS each beside a start strobe. It follows each of those cycles with a plain start, which shows whether the written value actually arrived.

Wrap-around needs BASE + OFFSET to exceed 1023. The table reaches it by loading a large base and flipping until the flag is 1. A second instance built without the swap receives the same stimulus to cover that variant.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
package dbuf_pkg;
  typedef enum logic [2:0] {
    RD_BASE   = 3'd0,
    RD_OFFSET = 3'd1,
    RD_TOPS   = 3'd2,
    RD_TOP    = 3'd3,
    RD_ITOPS  = 3'd4,
    RD_ITOP   = 3'd5,
    RD_FLAG   = 3'd6,
    RD_STATUS = 3'd7
  } rd_sel_e;

  localparam int unsigned N_IMM_REGS = 3;
  localparam int unsigned IDX_BASE   = 0;
  localparam int unsigned IDX_OFFSET = 1;
  localparam int unsigned IDX_ITOPS  = 2;
endpackage

// File: rtl/dbuf_imm_regs.sv
`timescale 1ns/1ps
module dbuf_imm_regs
  import dbuf_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IMM_REGS-1:0] wr_en,
  input  logic [AW-1:0]         wr_val,
  output logic [AW-1:0]         base_q,
  output logic [AW-1:0]         offset_q,
  output logic [AW-1:0]         itops_q
);
  logic [AW-1:0] regs_q [N_IMM_REGS];

  for (genvar g = 0; g < N_IMM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs_q[g] <= '0;
      else if (wr_en[g]) regs_q[g] <= wr_val;
    end
  end

  assign base_q   = regs_q[IDX_BASE];
  assign offset_q = regs_q[IDX_OFFSET];
  assign itops_q  = regs_q[IDX_ITOPS];
endmodule

// File: rtl/dbuf_flip_ctrl.sv
`timescale 1ns/1ps
module dbuf_flip_ctrl #(
  parameter int unsigned AW      = 10,
  parameter bit          FLIP_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flip_req,
  input  logic          reset_buf,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] offset_q,
  output logic          flag_q,
  output logic [AW-1:0] tops_q,
  output logic [AW-1:0] top_q
);
  logic [AW-1:0] upper_half;
  assign upper_half = base_q + offset_q;

  if (FLIP_EN) begin : g_flip
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
        tops_q <= '0;
        top_q  <= '0;
      end else if (flip_req) begin
        top_q  <= tops_q;
        flag_q <= ~flag_q;
        tops_q <= flag_q ? base_q : upper_half;
      end else if (reset_buf) begin
        flag_q <= 1'b0;
        tops_q <= base_q;
      end
    end
  end else begin : g_noflip
    logic unused_flip;
    assign unused_flip = flip_req ^ (^upper_half);
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
        tops_q <= '0;
        top_q  <= '0;
      end else if (reset_buf) begin
        flag_q <= 1'b0;
        tops_q <= base_q;
      end
    end
  end
endmodule

// File: rtl/dbuf_read_port.sv
`timescale 1ns/1ps
module dbuf_read_port
  import dbuf_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter int unsigned DW       = 32,
  parameter int unsigned STAT_POS = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] offset_q,
  input  logic [AW-1:0] tops_q,
  input  logic [AW-1:0] top_q,
  input  logic [AW-1:0] itops_q,
  input  logic [AW-1:0] itop_q,
  input  logic          flag_q,
  output logic [DW-1:0] data_q
);
  localparam int unsigned PAD = DW - AW;

  logic [DW-1:0] status_w;
  logic [DW-1:0] mux_w;

  always_comb begin
    status_w           = '0;
    status_w[STAT_POS] = flag_q;
  end

  always_comb begin
    case (sel)
      RD_BASE:   mux_w = {{PAD{1'b0}}, base_q};
      RD_OFFSET: mux_w = {{PAD{1'b0}}, offset_q};
      RD_TOPS:   mux_w = {{PAD{1'b0}}, tops_q};
      RD_TOP:    mux_w = {{PAD{1'b0}}, top_q};
      RD_ITOPS:  mux_w = {{PAD{1'b0}}, itops_q};
      RD_ITOP:   mux_w = {{PAD{1'b0}}, itop_q};
      RD_FLAG:   mux_w = {{(DW-1){1'b0}}, flag_q};
      default:   mux_w = status_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= mux_w;
  end
endmodule

// File: rtl/dbuf_addr_unit.sv
`timescale 1ns/1ps
module dbuf_addr_unit
  import dbuf_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter int unsigned IW       = 16,
  parameter int unsigned DW       = 32,
  parameter int unsigned STAT_POS = 7,
  parameter bit          FLIP_EN  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_base,
  input  logic          set_offset,
  input  logic          set_itops,
  input  logic          mp_start,
  input  logic [IW-1:0] imm,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          buf_flag,
  output logic [AW-1:0] tops_addr,
  output logic [AW-1:0] top_addr,
  output logic [AW-1:0] itop_val
);
  logic [N_IMM_REGS-1:0] wr_en;
  logic [AW-1:0]         base_q, offset_q, itops_q;
  logic                  unused_imm_hi;

  assign unused_imm_hi     = ^imm[IW-1:AW];
  assign wr_en[IDX_BASE]   = set_base;
  assign wr_en[IDX_OFFSET] = set_offset;
  assign wr_en[IDX_ITOPS]  = set_itops;

  dbuf_imm_regs #(.AW(AW)) u_imm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_val(imm[AW-1:0]),
    .base_q(base_q), .offset_q(offset_q), .itops_q(itops_q)
  );

  dbuf_flip_ctrl #(.AW(AW), .FLIP_EN(FLIP_EN)) u_flip (
    .clk(clk), .rst(rst), .flip_req(mp_start), .reset_buf(set_offset),
    .base_q(base_q), .offset_q(offset_q),
    .flag_q(buf_flag), .tops_q(tops_addr), .top_q(top_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)           itop_val <= '0;
    else if (mp_start) itop_val <= itops_q;
  end

  dbuf_read_port #(.AW(AW), .DW(DW), .STAT_POS(STAT_POS)) u_rd (
    .clk(clk), .rst(rst), .sel(rd_sel),
    .base_q(base_q), .offset_q(offset_q), .tops_q(tops_addr),
    .top_q(top_addr), .itops_q(itops_q), .itop_q(itop_val),
    .flag_q(buf_flag), .data_q(rd_data)
  );
endmodule

// File: rtl/dbuf_addr_unit_chk.sv
`timescale 1ns/1ps
module dbuf_addr_unit_chk #(
  parameter int unsigned AW       = 10,
  parameter int unsigned DW       = 32,
  parameter int unsigned STAT_POS = 7,
  parameter bit          FLIP_EN  = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          set_base,
  input logic          set_offset,
  input logic          mp_start,
  input logic [2:0]    rd_sel,
  input logic [DW-1:0] rd_data,
  input logic          buf_flag,
  input logic [AW-1:0] tops_addr,
  input logic [AW-1:0] top_addr,
  input logic [AW-1:0] itop_val
);
  // R1: offset write alone returns to buffer zero
  p_offset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (set_offset && !mp_start) |=> !buf_flag);

  // R2: base write alone leaves pointers and flag alone
  p_base_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (set_base && !set_offset && !mp_start) |=>
      ($stable(tops_addr) && $stable(top_addr) && $stable(buf_flag)));

  // R5: status word bit mirrors the flag
  p_status_mirror_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 3'd7) |=> (rd_data[STAT_POS] == $past(buf_flag)));

  // R8: reset clears outputs
  p_reset_zero_r8: assert property (@(posedge clk)
    rst |=> (!buf_flag && tops_addr == '0 && top_addr == '0 && itop_val == '0));

  if (FLIP_EN) begin : g_flip_chk
    // R4: swap moves old TOPS into TOP and toggles the flag
    p_flip_top_r4: assert property (@(posedge clk) disable iff (rst)
      mp_start |=> (top_addr == $past(tops_addr) && buf_flag != $past(buf_flag)));
  end else begin : g_noflip_chk
    // R9: no swap in this variant
    p_noflip_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (mp_start && !set_offset) |=>
        ($stable(buf_flag) && $stable(tops_addr) && $stable(top_addr)));
  end
endmodule

bind dbuf_addr_unit dbuf_addr_unit_chk #(
  .AW(AW), .DW(DW), .STAT_POS(STAT_POS), .FLIP_EN(FLIP_EN)
) u_chk (
  .clk(clk), .rst(rst), .set_base(set_base), .set_offset(set_offset),
  .mp_start(mp_start), .rd_sel(rd_sel), .rd_data(rd_data),
  .buf_flag(buf_flag), .tops_addr(tops_addr), .top_addr(top_addr),
  .itop_val(itop_val)
);

// File: tb/dbuf_addr_unit_bench.sv
`timescale 1ns/1ps
module dbuf_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_base = 1'b0, set_offset = 1'b0, set_itops = 1'b0, mp_start = 1'b0;
  logic [15:0] imm = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data, rd_data_nf;
  logic        buf_flag, buf_flag_nf;
  logic [9:0]  tops_addr, top_addr, itop_val;
  logic [9:0]  tops_nf, top_nf, itop_nf;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  dbuf_addr_unit u_dbuf_addr_unit (
    .clk(clk), .rst(rst), .set_base(set_base), .set_offset(set_offset),
    .set_itops(set_itops), .mp_start(mp_start), .imm(imm), .rd_sel(rd_sel),
    .rd_data(rd_data), .buf_flag(buf_flag), .tops_addr(tops_addr),
    .top_addr(top_addr), .itop_val(itop_val)
  );

  dbuf_addr_unit #(.FLIP_EN(1'b0)) u_dbuf_addr_unit_noflip (
    .clk(clk), .rst(rst), .set_base(set_base), .set_offset(set_offset),
    .set_itops(set_itops), .mp_start(mp_start), .imm(imm), .rd_sel(rd_sel),
    .rd_data(rd_data_nf), .buf_flag(buf_flag_nf), .tops_addr(tops_nf),
    .top_addr(top_nf), .itop_val(itop_nf)
  );

  // ops: bit0 set_base, bit1 set_offset, bit2 set_itops, bit3 mp_start
  typedef struct packed {
    logic [3:0]  ops;
    logic [15:0] imm;
    logic [9:0]  e_tops;
    logic [9:0]  e_top;
    logic        e_flag;
    logic [9:0]  e_itop;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 16'h0064,   10'd0,    10'd0, 1'b0,   10'd0},  // R2 base=100
    '{4'h2, 16'h00C8, 10'd100,    10'd0, 1'b0,   10'd0},  // R1 offset=200
    '{4'h4, 16'h002A, 10'd100,    10'd0, 1'b0,   10'd0},  // R3 itops=42
    '{4'h8, 16'h0000, 10'd300,  10'd100, 1'b1,  10'd42},  // R4 R6
    '{4'h8, 16'h0000, 10'd100,  10'd300, 1'b0,  10'd42},  // R4
    '{4'h8, 16'h0000, 10'd300,  10'd100, 1'b1,  10'd42},  // R4
    '{4'h1, 16'h03E8, 10'd300,  10'd100, 1'b1,  10'd42},  // R2 base=1000
    '{4'h8, 16'h0000, 10'd1000, 10'd300, 1'b0,  10'd42},  // R4
    '{4'h8, 16'h0000, 10'd176, 10'd1000, 1'b1,  10'd42},  // R10 wrap
    '{4'hA, 16'h0005, 10'd1000, 10'd176, 1'b0,  10'd42},  // R7 offset+start
    '{4'h8, 16'h0000, 10'd1005,10'd1000, 1'b1,  10'd42},  // R7 new offset used
    '{4'hC, 16'h03FF, 10'd1000,10'd1005, 1'b0,  10'd42},  // R7 itops+start
    '{4'h8, 16'h0000, 10'd1005,10'd1000, 1'b1,10'd1023},  // R6
    '{4'h2, 16'hFC07, 10'd1000,10'd1000, 1'b0,10'd1023},  // R1 high bits ignored
    '{4'h9, 16'h0010, 10'd1007,10'd1000, 1'b1,10'd1023},  // R7 base+start
    '{4'h8, 16'h0000, 10'd16,  10'd1007, 1'b0,10'd1023}   // R4 R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ops, input logic [15:0] val);
    set_base   = ops[0];
    set_offset = ops[1];
    set_itops  = ops[2];
    mp_start   = ops[3];
    imm        = val;
    @(negedge clk);
    {set_base, set_offset, set_itops, mp_start} = '0;
    imm = '0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    rd_sel = sel;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (400) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 reset tops", {22'd0, tops_addr}, 32'd0);
    chk("R8 reset top",  {22'd0, top_addr}, 32'd0);
    chk("R8 reset flag", {31'd0, buf_flag}, 32'd0);
    chk("R8 reset itop", {22'd0, itop_val}, 32'd0);
    chk("R8 reset rd_data", rd_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].ops, VEC[i].imm);
      chk($sformatf("R4 tops step %0d", i), {22'd0, tops_addr}, {22'd0, VEC[i].e_tops});
      chk($sformatf("R4 top step %0d", i),  {22'd0, top_addr},  {22'd0, VEC[i].e_top});
      chk($sformatf("R4 flag step %0d", i), {31'd0, buf_flag},  {31'd0, VEC[i].e_flag});
      chk($sformatf("R6 itop step %0d", i), {22'd0, itop_val},  {22'd0, VEC[i].e_itop});
    end

    // R9: variant without swap saw the same stimulus
    chk("R9 noflip tops", {22'd0, tops_nf}, 32'd1000);
    chk("R9 noflip top",  {22'd0, top_nf}, 32'd0);
    chk("R9 noflip flag", {31'd0, buf_flag_nf}, 32'd0);
    chk("R6 noflip itop", {22'd0, itop_nf}, 32'd1023);

    // R11 read port, every select
    rd(3'd0, 32'd16,   "R11 read base");
    rd(3'd1, 32'd7,    "R11 read offset");
    rd(3'd2, 32'd16,   "R11 read tops");
    rd(3'd3, 32'd1007, "R11 read top");
    rd(3'd4, 32'd1023, "R11 read itops");
    rd(3'd5, 32'd1023, "R11 read itop");
    rd(3'd6, 32'd0,    "R5 read flag");
    rd(3'd7, 32'd0,    "R5 read status");

    apply(4'h8, 16'h0000);
    chk("R4 tops base+offset", {22'd0, tops_addr}, 32'd23);
    rd(3'd6, 32'd1,    "R5 read flag set");
    rd(3'd7, 32'h80,   "R5 read status set");

    // R8: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 rerun tops", {22'd0, tops_addr}, 32'd0);
    chk("R8 rerun flag", {31'd0, buf_flag}, 32'd0);
    chk("R8 rerun itop", {22'd0, itop_val}, 32'd0);
    rd(3'd0, 32'd0, "R8 rerun base");
    rd(3'd4, 32'd0, "R8 rerun itops");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule